// File: doc/BRIEF.md
# Dual-Input Both-Edge Set/Clear Flag

This block keeps one flag bit that is steered by transitions, not levels, on two single-bit inputs that arrive without any timing relation to the system clock. Any change on the clear input, whether it rises or falls, drives the flag low. Any change on the set input, in either direction, drives the flag high. Between such events the flag holds its value for as long as the inputs stay still.

Each raw input first passes through a chain of flip-flops that resynchronizes it into the clock domain. A change detector then compares the newest synchronized sample with the one before it, and one register merges both event paths into the flag. The register also produces two registered one-cycle pulses that show which input was seen to change. The two inputs are expected never to change in the same cycle. If both events still land together, the set event takes priority.

Top module: `toggle_flag`

## Requirements
- R1: A transition of `clr_in` in either direction drives `flag` to 0, unless a set event is resolved in the same cycle.
- R2: A transition of `set_in` in either direction drives `flag` to 1.
- R3: With the default `SYNC_STAGES` of 2, `flag` shows the effect of an input transition after the third rising clock edge. The first of these three edges is the first edge that samples the new input level, so the latency is `SYNC_STAGES`+1 edges.
- R4: Reset is synchronous and active low. A rising edge that samples `rst_n` at 0 leaves `flag`, `clr_pulse` and `set_pulse` at 0.
- R5: When neither input has a resolved transition, `flag` keeps its previous value.
- R6: When a clear event and a set event are resolved in the same cycle, `flag` becomes 1, because set wins.
- R7: `clr_pulse` and `set_pulse` are registered. Each is high for exactly one cycle per synchronized transition of its input, in the same cycle that `flag` takes the resulting value. Transitions on consecutive cycles give pulses on consecutive cycles.
- R8: If both inputs stay at one level for at least `SYNC_STAGES`+1 cycles while reset is held, no pulse and no flag change follow the release of reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| clr_in | input | 1 | Raw clear-event input, asynchronous to `clk` |
| set_in | input | 1 | Raw set-event input, asynchronous to `clk` |
| flag | output | 1 | Registered flag |
| clr_pulse | output | 1 | One-cycle marker of a resolved `clr_in` transition |
| set_pulse | output | 1 | One-cycle marker of a resolved `set_in` transition |

## Verification
A wrong synchronizer or previous-sample register shows at the ports as a pulse and a flag change that come one cycle early or late. It can also show as a missing or doubled pulse, and this is visible within `SYNC_STAGES`+1 edges of the stimulus. A wrong flag register shows as a flag that drifts with no pulse, or that takes the wrong value when both pulses are high, in the very cycle it happens. The bench runs a behavioural model that indexes a history of sampled inputs by latency. It compares all three outputs every cycle, so any such fault is seen on the first cycle it appears.

// File: rtl/toggle_flag_pkg.sv
`timescale 1ns/1ps
package toggle_flag_pkg;

  localparam int unsigned CH_CLR = 0;
  localparam int unsigned CH_SET = 1;
  localparam int unsigned NUM_CH = 2;

  typedef enum logic [1:0] {
    FLAG_HOLD = 2'd0,
    FLAG_CLR  = 2'd1,
    FLAG_SET  = 2'd2
  } flag_op_e;

  // Set has priority over clear when both events resolve together.
  function automatic flag_op_e pick_op(input logic clr_ev, input logic set_ev);
    if (set_ev)      return FLAG_SET;
    else if (clr_ev) return FLAG_CLR;
    else             return FLAG_HOLD;
  endfunction

endpackage

// File: rtl/tf_sync.sv
`timescale 1ns/1ps
module tf_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  // No reset on purpose: the chain keeps tracking the input during reset,
  // so the detector behind it is primed when reset releases.
  always_ff @(posedge clk) begin
    chain[0] <= d;
    for (int i = 1; i < int'(STAGES); i++) begin
      chain[i] <= chain[i-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/tf_chg_det.sv
`timescale 1ns/1ps
module tf_chg_det (
  input  logic clk,
  input  logic lvl,
  output logic chg
);
  logic prev;

  always_ff @(posedge clk) begin
    prev <= lvl;
  end

  assign chg = lvl ^ prev;
endmodule

// File: rtl/tf_flag_reg.sv
`timescale 1ns/1ps
module tf_flag_reg
  import toggle_flag_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] chg,
  output logic              flag_q,
  output logic [NUM_CH-1:0] pulse_q
);
  flag_op_e op;

  assign op = pick_op(chg[CH_CLR], chg[CH_SET]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_q  <= 1'b0;
      pulse_q <= '0;
    end else begin
      pulse_q <= chg;
      case (op)
        FLAG_SET: flag_q <= 1'b1;
        FLAG_CLR: flag_q <= 1'b0;
        default:  flag_q <= flag_q;
      endcase
    end
  end
endmodule

// File: rtl/toggle_flag.sv
`timescale 1ns/1ps
module toggle_flag
  import toggle_flag_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_in,
  input  logic set_in,
  output logic flag,
  output logic clr_pulse,
  output logic set_pulse
);
  logic [NUM_CH-1:0] raw;
  logic [NUM_CH-1:0] synced;
  logic [NUM_CH-1:0] chg;
  logic [NUM_CH-1:0] pulse_q;

  assign raw[CH_CLR] = clr_in;
  assign raw[CH_SET] = set_in;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    tf_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk (clk),
      .d   (raw[c]),
      .q   (synced[c])
    );
    tf_chg_det u_det (
      .clk (clk),
      .lvl (synced[c]),
      .chg (chg[c])
    );
  end

  tf_flag_reg u_flag (
    .clk     (clk),
    .rst_n   (rst_n),
    .chg     (chg),
    .flag_q  (flag),
    .pulse_q (pulse_q)
  );

  assign clr_pulse = pulse_q[CH_CLR];
  assign set_pulse = pulse_q[CH_SET];
endmodule

// File: rtl/toggle_flag_chk.sv
`timescale 1ns/1ps
module toggle_flag_chk (
  input logic clk,
  input logic rst_n,
  input logic flag,
  input logic clr_pulse,
  input logic set_pulse
);
  // R1: a lone clear pulse comes with a low flag
  a_r1_clear_lowers: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_pulse && !set_pulse) |-> !flag);

  // R2: a set pulse comes with a high flag
  a_r2_set_raises: assert property (@(posedge clk) disable iff (!rst_n)
    set_pulse |-> flag);

  // R4: synchronous reset clears all outputs
  a_r4_reset_clears: assert property (@(posedge clk)
    !rst_n |=> (!flag && !clr_pulse && !set_pulse));

  // R5: no pulse means the flag did not move
  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_pulse && !set_pulse) |-> $stable(flag));

  // R6: a falling flag needs a clear pulse with no set pulse
  a_r6_fall_only_on_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag) |-> (clr_pulse && !set_pulse));

  // R7: a rising flag is always marked by a set pulse
  a_r7_rise_marked: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> set_pulse);
endmodule

bind toggle_flag toggle_flag_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .flag      (flag),
  .clr_pulse (clr_pulse),
  .set_pulse (set_pulse)
);

// File: tb/tb_toggle_flag.sv
`timescale 1ns/1ps
module tb_toggle_flag;
  localparam real CLK_NS = 20.0;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clr_in = 1'b1;
  logic set_in = 1'b1;
  logic flag, clr_pulse, set_pulse;

  int total = 0;
  int bad = 0;
  bit done = 0;

  toggle_flag dut (
    .clk(clk), .rst_n(rst_n), .clr_in(clr_in), .set_in(set_in),
    .flag(flag), .clr_pulse(clr_pulse), .set_pulse(set_pulse)
  );

  always #(CLK_NS/2) clk = ~clk;

  task automatic chk(input string tag, input string what, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0b expected=%0b t=%0t", tag, what, act, exp, $time);
    end
  endtask

  // Behavioural reference: history of sampled inputs; pulse after edge n
  // equals sample[n-2] != sample[n-3].
  bit hc[$];
  bit hs[$];
  bit e_flag = 0, e_cp = 0, e_sp = 0;
  bit e_rst = 1;
  int since_rel = 0;
  bit started = 0;

  always @(posedge clk) begin
    hc.push_front(clr_in);
    hs.push_front(set_in);
    if (hc.size() > 8) begin
      void'(hc.pop_back());
      void'(hs.pop_back());
    end
    started = 1;
    if (!rst_n) begin
      e_flag = 0; e_cp = 0; e_sp = 0; e_rst = 1; since_rel = 0;
    end else begin
      e_rst = 0;
      since_rel++;
      e_cp = (hc.size() >= 4) ? (hc[2] ^ hc[3]) : 1'b0;
      e_sp = (hs.size() >= 4) ? (hs[2] ^ hs[3]) : 1'b0;
      if (e_sp) e_flag = 1;
      else if (e_cp) e_flag = 0;
    end
  end

  always @(negedge clk) begin
    if (started && !done) begin
      string tf;
      string tp;
      if (e_rst) begin tf = "R4"; tp = "R4"; end
      else if (since_rel <= 3) begin tf = "R8"; tp = "R8"; end
      else begin
        tp = "R7";
        if (e_sp && e_cp) tf = "R6";
        else if (e_sp) tf = "R2";
        else if (e_cp) tf = "R1";
        else tf = "R5";
      end
      chk(tf, "flag", flag, e_flag);
      chk(tp, "clr_pulse", clr_pulse, e_cp);
      chk(tp, "set_pulse", set_pulse, e_sp);
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin : watchdog
    #(CLK_NS * 150000);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    // R4/R8: reset with inputs held high, then release
    idle(6);
    rst_n = 1'b1;
    idle(6);

    // R3: latency of set edge (falling set_in) is three edges
    set_in = 1'b0;
    @(posedge clk); @(posedge clk); @(negedge clk);
    chk("R3", "flag after 2 edges", flag, 1'b0);
    @(posedge clk); @(negedge clk);
    chk("R3", "flag after 3 edges", flag, 1'b1);
    idle(4);

    // R1: falling clear input clears, rising clear input keeps it clear
    clr_in = 1'b0; idle(5);
    chk("R1", "flag after clr fall", flag, 1'b0);
    set_in = 1'b1; idle(5);
    chk("R2", "flag after set rise", flag, 1'b1);
    clr_in = 1'b1; idle(5);
    chk("R1", "flag after clr rise", flag, 1'b0);
    idle(20);
    chk("R5", "flag held", flag, 1'b0);

    // R6: both inputs toggle in the same cycle, set wins
    clr_in = ~clr_in; set_in = ~set_in; idle(5);
    chk("R6", "flag after joint change", flag, 1'b1);

    // R7: back-to-back toggles on each input
    for (int i = 0; i < 6; i++) begin clr_in = ~clr_in; idle(1); end
    idle(5);
    for (int i = 0; i < 5; i++) begin set_in = ~set_in; idle(1); end
    idle(5);

    // Mixed random traffic, mostly one input per cycle
    for (int i = 0; i < 3000; i++) begin
      int r = int'($urandom_range(0, 9));
      if (r == 0) clr_in = ~clr_in;
      else if (r == 1) set_in = ~set_in;
      else if (r == 2 && (i % 50 == 0)) begin clr_in = ~clr_in; set_in = ~set_in; end
      idle(1);
    end
    idle(5);

    // R4/R8: reset mid-run with a high flag, inputs steady through it
    set_in = ~set_in; idle(5);
    rst_n = 1'b0; idle(5);
    chk("R4", "flag in reset", flag, 1'b0);
    rst_n = 1'b1; idle(6);
    chk("R8", "no pulse after release", clr_pulse | set_pulse, 1'b0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule